// File: doc/BRIEF.md
# Overlay window command sequencer

This block runs one command on a memory device that exposes its command interface as a memory-mapped window. A host hands it a 16-bit command code together with a 32-bit data word, a 32-bit target address and a 32-bit count word. It then carries out the whole exchange with the device on its own. First it opens the window through the memory controller's mode-register port. It loads the command registers and, for the two buffered program commands, streams payload words into the device's program buffer. It then triggers execution and polls the device status until the ready bit appears. Finally it closes the window again and reports completion and error to the host.

Two device arrangements are supported, chosen per command by `pair_mode`. The first is a single 16-bit device, where each register sits two bytes apart. The second is two 16-bit devices stacked on a 32-bit bus, where registers sit four bytes apart. In the stacked case every command-register access is repeated for the upper device at the register address plus two. A programmable poll limit keeps a device that never becomes ready from hanging the engine.

Top module: `cmdwin_seq`

## Requirements
- R1: An accepted start first issues a mode-register config write (`mr_sel`=0) of 0x00008018 in single mode or 0x80000018 in stacked mode, then a mode-register data write (`mr_sel`=1) of 0x00000001, before any window access.
- R2: The command registers are then written in a fixed order, each with a 16-bit value. The order is code at word offset 0x40, data low half at 0x42, address low at 0x44, address high at 0x45, count low at 0x48 and count high at 0x49. The byte address is WIN_BASE + offset × W, where W is 2 in single mode and 4 in stacked mode.
- R3: In stacked mode each command-register write is followed at once by a second write at the same address + 2. That copy has the same value, except the data register copy, which carries data bits 31:16.
- R4: For codes 0x00E9 and 0x00EA the engine reads the pointer register at word offset 0x08. It then writes exactly count payload words, word i going to WIN_BASE + pointer + i. One payload word is taken per cycle where `pay_valid` and `pay_ready` are both high. Any other code skips the pointer read and the fill.
- R5: Execution is triggered by writing 0x0001 to word offset 0x60, repeated at +2 in stacked mode.
- R6: The engine then reads status at word offset 0x66, and in stacked mode also the upper half at +2, low half first. Ready means bit 7 is set in single mode, or bits 7 and 23 are both set in {upper, lower}. Reads repeat until ready.
- R7: After max(`poll_limit`, 1) status evaluations that are not ready, polling stops and `error` is set. A ready result on the last allowed evaluation is not an error.
- R8: Once polling ends, by ready or by timeout, the engine writes 0x00008018 or 0x80000018 to config and then 0x00000002 to data. `done` pulses for one cycle right after that last write is acknowledged. `error` stays valid from `done` until the next accepted start.
- R9: `busy` rises the cycle after an accepted start and falls in the cycle `done` is high. A start seen while busy has no effect.
- R10: A bus or mode-register request keeps its address, direction and data unchanged until acknowledged. The two ports never request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, taken only when idle |
| pair_mode | input | 1 | 1 = two stacked 16-bit devices, 0 = single device |
| cmd_code | input | 16 | Command code |
| cmd_data | input | 32 | Command data word |
| cmd_addr | input | 32 | Target address |
| cmd_count | input | 32 | Count word (payload words for buffered commands) |
| poll_limit | input | LW | Maximum status evaluations, 0 acts as 1 |
| pay_valid | input | 1 | Payload word available |
| pay_data | input | 16 | Payload word |
| pay_ready | output | 1 | Engine takes the payload word this cycle |
| bus_req | output | 1 | Window access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Window byte address |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Access completed this cycle |
| bus_rdata | input | 16 | Read data, valid with bus_ack |
| mr_req | output | 1 | Mode-register write request |
| mr_sel | output | 1 | 0 = config register, 1 = data register |
| mr_wdata | output | 32 | Mode-register write data |
| mr_ack | input | 1 | Mode-register write completed |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Poll timeout result |

## Verification
The bench sweeps both device arrangements against a plain command and both buffered codes, with counts of zero, one and four and with acknowledge latencies of zero to two cycles. Each run's full access trace is compared with a trace built from the requirements. This separates ordering, address scaling, the duplicated upper-device writes, the fill placement and the skipped fill. Status patterns that turn ready on the first poll, on the last allowed poll, one poll too late or never, and with the upper half lagging the lower half, test the ready mask, the assembly of the two halves and the limit arithmetic including a limit of zero. A second start pulse in mid-command shows that it is ignored.

// File: rtl/cmdwin_pkg.sv
package cmdwin_pkg;

    // Device word offsets: decoded by the device, so fixed.
    localparam logic [7:0] WOFS_PTR  = 8'h08;
    localparam logic [7:0] WOFS_CODE = 8'h40;
    localparam logic [7:0] WOFS_DATA = 8'h42;
    localparam logic [7:0] WOFS_ADDL = 8'h44;
    localparam logic [7:0] WOFS_ADDH = 8'h45;
    localparam logic [7:0] WOFS_CNTL = 8'h48;
    localparam logic [7:0] WOFS_CNTH = 8'h49;
    localparam logic [7:0] WOFS_EXEC = 8'h60;
    localparam logic [7:0] WOFS_STAT = 8'h66;

    localparam logic [15:0] OP_BUF_PROG = 16'h00E9;
    localparam logic [15:0] OP_BUF_OVR  = 16'h00EA;

    localparam logic [15:0] CFG_SEL     = 16'h8000;
    localparam logic [15:0] CFG_LOW     = 16'h0018;
    localparam logic [31:0] MR_OPEN     = 32'h0000_0001;
    localparam logic [31:0] MR_CLOSE    = 32'h0000_0002;
    localparam logic [15:0] TRIG_VALUE  = 16'h0001;

    localparam int          NUM_LOAD    = 6;
    localparam logic [2:0]  LAST_STEP   = 3'(NUM_LOAD - 1);

    typedef enum logic [3:0] {
        ST_IDLE, ST_OPEN_CFG, ST_OPEN_DAT, ST_LOAD, ST_PTR,
        ST_FILL, ST_TRIG, ST_POLL, ST_CLOSE_CFG, ST_CLOSE_DAT
    } cw_state_e;

    typedef enum logic [2:0] {
        AS_LOAD, AS_PTR, AS_FILL, AS_TRIG, AS_POLL
    } cw_access_e;

    function automatic logic [7:0] load_offset(input logic [2:0] step);
        case (step)
            3'd0:    return WOFS_CODE;
            3'd1:    return WOFS_DATA;
            3'd2:    return WOFS_ADDL;
            3'd3:    return WOFS_ADDH;
            3'd4:    return WOFS_CNTL;
            default: return WOFS_CNTH;
        endcase
    endfunction

    function automatic logic [31:0] mr_cfg_word(input logic pair);
        return pair ? {CFG_SEL, CFG_LOW} : {16'h0000, CFG_SEL | CFG_LOW};
    endfunction

endpackage

// File: rtl/cmdwin_addr_gen.sv
module cmdwin_addr_gen
    import cmdwin_pkg::*;
#(
    parameter int          AW       = 32,
    parameter logic [AW-1:0] WIN_BASE = '0
) (
    input  cw_access_e    access,
    input  logic [2:0]    step,
    input  logic          half,
    input  logic          pair,
    input  logic [15:0]   code,
    input  logic [31:0]   data,
    input  logic [31:0]   addr,
    input  logic [31:0]   count,
    input  logic [AW-1:0] ptr,
    input  logic [31:0]   idx,
    input  logic [15:0]   word,
    output logic [AW-1:0] bus_addr,
    output logic [15:0]   bus_wdata
);

    logic [7:0]    wofs;
    logic [AW-1:0] scaled;
    logic [AW-1:0] hoff;

    always_comb begin
        case (access)
            AS_LOAD: wofs = load_offset(step);
            AS_PTR:  wofs = WOFS_PTR;
            AS_TRIG: wofs = WOFS_EXEC;
            default: wofs = WOFS_STAT;
        endcase
        scaled = pair ? AW'({wofs, 2'b00}) : AW'({wofs, 1'b0});
        hoff   = half ? AW'(2) : '0;

        bus_addr  = WIN_BASE + scaled + hoff;
        bus_wdata = '0;
        case (access)
            AS_LOAD: begin
                case (step)
                    3'd0:    bus_wdata = code;
                    3'd1:    bus_wdata = half ? data[31:16] : data[15:0];
                    3'd2:    bus_wdata = addr[15:0];
                    3'd3:    bus_wdata = addr[31:16];
                    3'd4:    bus_wdata = count[15:0];
                    default: bus_wdata = count[31:16];
                endcase
            end
            AS_FILL: begin
                bus_addr  = WIN_BASE + ptr + AW'(idx);
                bus_wdata = word;
            end
            AS_TRIG: bus_wdata = TRIG_VALUE;
            default: bus_wdata = '0;
        endcase
    end

endmodule

// File: rtl/cmdwin_poll_eval.sv
module cmdwin_poll_eval #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          take_lo,
    input  logic          eval,
    input  logic [15:0]   rdata,
    input  logic          pair,
    input  logic [LW-1:0] limit,
    output logic          ready,
    output logic          last
);

    typedef struct packed {
        logic [15:0]   lo;
        logic [LW-1:0] cnt;
    } poll_t;

    poll_t q, d;
    logic [31:0]   assembled;
    logic [31:0]   mask;
    logic [LW-1:0] lim_eff;

    always_comb begin
        assembled = pair ? {rdata, q.lo} : {16'h0000, rdata};
        mask      = pair ? 32'h0080_0080 : 32'h0000_0080;
        ready     = (assembled & mask) == mask;
        lim_eff   = (limit == '0) ? LW'(1) : limit;
        last      = ((LW + 1)'(q.cnt) + (LW + 1)'(1)) >= {1'b0, lim_eff};

        d = q;
        if (clear) begin
            d.cnt = '0;
        end else if (eval) begin
            d.cnt = q.cnt + LW'(1);
        end
        if (take_lo) begin
            d.lo = rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/cmdwin_seq.sv
module cmdwin_seq
    import cmdwin_pkg::*;
#(
    parameter int            AW       = 32,
    parameter int            LW       = 16,
    parameter logic [AW-1:0] WIN_BASE = AW'(32'h0001_0000)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          pair_mode,
    input  logic [15:0]   cmd_code,
    input  logic [31:0]   cmd_data,
    input  logic [31:0]   cmd_addr,
    input  logic [31:0]   cmd_count,
    input  logic [LW-1:0] poll_limit,
    input  logic          pay_valid,
    input  logic [15:0]   pay_data,
    output logic          pay_ready,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [15:0]   bus_wdata,
    input  logic          bus_ack,
    input  logic [15:0]   bus_rdata,
    output logic          mr_req,
    output logic          mr_sel,
    output logic [31:0]   mr_wdata,
    input  logic          mr_ack,
    output logic          busy,
    output logic          done,
    output logic          error
);

    typedef struct packed {
        cw_state_e     st;
        logic [2:0]    step;
        logic          half;
        logic          pair;
        logic [15:0]   code;
        logic [31:0]   data;
        logic [31:0]   addr;
        logic [31:0]   count;
        logic [LW-1:0] limit;
        logic [AW-1:0] ptr;
        logic [31:0]   idx;
        logic          have;
        logic [15:0]   word;
        logic          err;
        logic          done;
    } seq_t;

    seq_t q, d;

    cw_access_e access;
    logic       is_buf;
    logic       last_half;
    logic       poll_clear, poll_take_lo, poll_eval;
    logic       poll_ready, poll_last;

    assign is_buf    = (q.code == OP_BUF_PROG) || (q.code == OP_BUF_OVR);
    assign last_half = !q.pair || q.half;

    always_comb begin
        case (q.st)
            ST_LOAD: access = AS_LOAD;
            ST_PTR:  access = AS_PTR;
            ST_FILL: access = AS_FILL;
            ST_TRIG: access = AS_TRIG;
            default: access = AS_POLL;
        endcase
    end

    cmdwin_addr_gen #(
        .AW       (AW),
        .WIN_BASE (WIN_BASE)
    ) u_addr (
        .access    (access),
        .step      (q.step),
        .half      (q.half),
        .pair      (q.pair),
        .code      (q.code),
        .data      (q.data),
        .addr      (q.addr),
        .count     (q.count),
        .ptr       (q.ptr),
        .idx       (q.idx),
        .word      (q.word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    assign poll_clear   = (q.st == ST_TRIG) && bus_ack && last_half;
    assign poll_take_lo = (q.st == ST_POLL) && bus_ack && !last_half;
    assign poll_eval    = (q.st == ST_POLL) && bus_ack && last_half;

    cmdwin_poll_eval #(
        .LW (LW)
    ) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (poll_clear),
        .take_lo (poll_take_lo),
        .eval    (poll_eval),
        .rdata   (bus_rdata),
        .pair    (q.pair),
        .limit   (q.limit),
        .ready   (poll_ready),
        .last    (poll_last)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st    = ST_OPEN_CFG;
                    d.pair  = pair_mode;
                    d.code  = cmd_code;
                    d.data  = cmd_data;
                    d.addr  = cmd_addr;
                    d.count = cmd_count;
                    d.limit = poll_limit;
                    d.step  = '0;
                    d.half  = 1'b0;
                    d.have  = 1'b0;
                    d.err   = 1'b0;
                end
            end
            ST_OPEN_CFG: if (mr_ack) d.st = ST_OPEN_DAT;
            ST_OPEN_DAT: if (mr_ack) d.st = ST_LOAD;
            ST_LOAD: begin
                if (bus_ack) begin
                    if (!last_half) begin
                        d.half = 1'b1;
                    end else begin
                        d.half = 1'b0;
                        if (q.step == LAST_STEP) begin
                            d.step = '0;
                            d.st   = is_buf ? ST_PTR : ST_TRIG;
                        end else begin
                            d.step = q.step + 3'd1;
                        end
                    end
                end
            end
            ST_PTR: begin
                if (bus_ack) begin
                    d.ptr  = AW'(bus_rdata);
                    d.idx  = '0;
                    d.have = 1'b0;
                    d.st   = (q.count == '0) ? ST_TRIG : ST_FILL;
                end
            end
            ST_FILL: begin
                if (!q.have) begin
                    if (pay_valid) begin
                        d.have = 1'b1;
                        d.word = pay_data;
                    end
                end else if (bus_ack) begin
                    d.have = 1'b0;
                    d.idx  = q.idx + 32'd1;
                    if (q.idx + 32'd1 == q.count) d.st = ST_TRIG;
                end
            end
            ST_TRIG: begin
                if (bus_ack) begin
                    if (!last_half) begin
                        d.half = 1'b1;
                    end else begin
                        d.half = 1'b0;
                        d.st   = ST_POLL;
                    end
                end
            end
            ST_POLL: begin
                if (bus_ack) begin
                    if (!last_half) begin
                        d.half = 1'b1;
                    end else begin
                        d.half = 1'b0;
                        if (poll_ready) begin
                            d.st = ST_CLOSE_CFG;
                        end else if (poll_last) begin
                            d.err = 1'b1;
                            d.st  = ST_CLOSE_CFG;
                        end
                    end
                end
            end
            ST_CLOSE_CFG: if (mr_ack) d.st = ST_CLOSE_DAT;
            ST_CLOSE_DAT: begin
                if (mr_ack) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_req   = (q.st == ST_LOAD) || (q.st == ST_PTR) || (q.st == ST_TRIG) ||
                       (q.st == ST_POLL) || ((q.st == ST_FILL) && q.have);
    assign bus_we    = (q.st == ST_LOAD) || (q.st == ST_FILL) || (q.st == ST_TRIG);
    assign pay_ready = (q.st == ST_FILL) && !q.have;
    assign mr_req    = (q.st == ST_OPEN_CFG) || (q.st == ST_OPEN_DAT) ||
                       (q.st == ST_CLOSE_CFG) || (q.st == ST_CLOSE_DAT);
    assign mr_sel    = (q.st == ST_OPEN_DAT) || (q.st == ST_CLOSE_DAT);
    assign mr_wdata  = (q.st == ST_OPEN_DAT)  ? MR_OPEN  :
                       (q.st == ST_CLOSE_DAT) ? MR_CLOSE : mr_cfg_word(q.pair);
    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign error     = q.err;

endmodule

// File: rtl/cmdwin_seq_chk.sv
module cmdwin_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          pay_ready,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [15:0]   bus_wdata,
    input logic          bus_ack,
    input logic          mr_req,
    input logic          mr_sel,
    input logic [31:0]   mr_wdata,
    input logic          mr_ack,
    input logic          busy,
    input logic          done,
    input logic          error
);

    assert_one_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && mr_req));

    assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    assert_mr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mr_req && !mr_ack |=> mr_req && $stable(mr_sel) && $stable(mr_wdata));

    assert_open_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mr_req && !mr_sel);

    assert_fill_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready |-> busy && !bus_req && !mr_req);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_error_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(error));

    assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

bind cmdwin_seq cmdwin_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pay_ready (pay_ready),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .mr_req    (mr_req),
    .mr_sel    (mr_sel),
    .mr_wdata  (mr_wdata),
    .mr_ack    (mr_ack),
    .busy      (busy),
    .done      (done),
    .error     (error)
);

// File: tb/cmdwin_seq_tb.sv
`timescale 1ns/1ps
module cmdwin_seq_tb;

    localparam int          AW   = 32;
    localparam int          LW   = 8;
    localparam logic [31:0] BASE = 32'h0004_0000;

    logic          clk, rst_n;
    logic          start, pair_mode;
    logic [15:0]   cmd_code;
    logic [31:0]   cmd_data, cmd_addr, cmd_count;
    logic [LW-1:0] poll_limit;
    logic          pay_valid;
    logic [15:0]   pay_data;
    logic          pay_ready;
    logic          bus_req, bus_we, bus_ack;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_wdata, bus_rdata;
    logic          mr_req, mr_sel, mr_ack;
    logic [31:0]   mr_wdata;
    logic          busy, done, error;

    cmdwin_seq #(.AW(AW), .LW(LW), .WIN_BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pair_mode(pair_mode),
        .cmd_code(cmd_code), .cmd_data(cmd_data), .cmd_addr(cmd_addr),
        .cmd_count(cmd_count), .poll_limit(poll_limit),
        .pay_valid(pay_valid), .pay_data(pay_data), .pay_ready(pay_ready),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .mr_req(mr_req), .mr_sel(mr_sel), .mr_wdata(mr_wdata), .mr_ack(mr_ack),
        .busy(busy), .done(done), .error(error)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // trace: kind 0 = mode write (addr = select), 1 = bus write, 2 = bus read
    int          log_k [256];
    logic [31:0] log_a [256];
    logic [31:0] log_d [256];
    int          log_n;
    int          exp_k [256];
    logic [31:0] exp_a [256];
    logic [31:0] exp_d [256];
    int          exp_n;

    task automatic check(input bit ok, input string req, input string msg,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, msg, act, expv);
        end
    endtask

    task automatic add_log(input int k, input logic [31:0] a, input logic [31:0] dv);
        if (log_n < 256) begin
            log_k[log_n] = k; log_a[log_n] = a; log_d[log_n] = dv;
        end
        log_n++;
    endtask

    task automatic add_exp(input int k, input logic [31:0] a, input logic [31:0] dv);
        exp_k[exp_n] = k; exp_a[exp_n] = a; exp_d[exp_n] = dv;
        exp_n++;
    endtask

    function automatic logic [15:0] stat_half(input int p, input int at);
        return (p >= at) ? 16'h0080 : 16'hFF7F;
    endfunction

    task automatic run(input bit pair, input logic [15:0] code, input logic [31:0] data,
                       input logic [31:0] addr, input logic [31:0] cnt,
                       input logic [LW-1:0] lim, input int rl, input int rh,
                       input int lat, input bit extra, input string tag);
        int          w      = pair ? 4 : 2;
        logic [31:0] ptr    = 32'h0000_0100 + (pair ? 32'h40 : 32'h0);
        int          c      = 0;
        bit          got    = 0;
        bit          take   = 0;
        int          pidx   = 0;
        int          bwait  = 0;
        int          mwait  = 0;
        int          stat_n = 0;
        int          ofs [6] = '{'h40, 'h42, 'h44, 'h45, 'h48, 'h49};
        logic [31:0] cfg    = pair ? 32'h8000_0018 : 32'h0000_8018;
        logic [15:0] rd;
        logic [15:0] v;
        int          rdy_p, lim_eff, npoll;
        bit          exp_err;
        bit          ok;
        int          bad;

        log_n = 0; exp_n = 0;
        pair_mode = pair; cmd_code = code; cmd_data = data; cmd_addr = addr;
        cmd_count = cnt; poll_limit = lim; pay_data = 16'hA000;

        while (!got && c < 4000) begin
            @(negedge clk);
            start = (c == 0) || (extra && c == 6);
            if (c == 1) check(busy == 1'b1, "R9", {tag, " busy after start"}, 32'(busy), 1);
            if (done) got = 1;
            if (take) pidx++;
            take     = pay_ready && pay_valid;
            pay_data = 16'hA000 + 16'(pidx);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                if (bwait < lat) bwait++;
                else begin
                    bwait   = 0;
                    bus_ack = 1'b1;
                    if (bus_we) add_log(1, bus_addr, 32'(bus_wdata));
                    else begin
                        if (bus_addr == BASE + 32'(8 * w)) rd = ptr[15:0];
                        else if (bus_addr == BASE + 32'('h66 * w)) begin
                            stat_n++;
                            rd = stat_half(stat_n, rl);
                        end else if (bus_addr == BASE + 32'('h66 * w + 2)) rd = stat_half(stat_n, rh);
                        else rd = 16'hDEAD;
                        bus_rdata = rd;
                        add_log(2, bus_addr, 32'(rd));
                    end
                end
            end
            if (mr_ack) begin
                mr_ack = 1'b0;
            end else if (mr_req) begin
                if (mwait < lat) mwait++;
                else begin
                    mwait  = 0;
                    mr_ack = 1'b1;
                    add_log(0, 32'(mr_sel), mr_wdata);
                end
            end
            c++;
        end
        start = 1'b0;
        check(got, "R8", {tag, " done seen"}, 32'(got), 1);
        check(error == 1'b0 || error == 1'b1, "R8", {tag, " error known"}, 32'(error), 0);

        rdy_p   = pair ? ((rl > rh) ? rl : rh) : rl;
        lim_eff = (lim == 0) ? 1 : int'(lim);
        npoll   = (rdy_p < lim_eff) ? rdy_p : lim_eff;
        exp_err = rdy_p > lim_eff;
        check(error == exp_err, "R7", {tag, " error at done"}, 32'(error), 32'(exp_err));

        @(negedge clk);
        if (mr_ack) mr_ack = 1'b0;
        check(done == 1'b0 && busy == 1'b0, "R9", {tag, " single done, no rerun"},
              {30'd0, done, busy}, 0);

        // expected trace from the requirements
        add_exp(0, 0, cfg);
        add_exp(0, 1, 32'h1);
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: v = code;
                1: v = data[15:0];
                2: v = addr[15:0];
                3: v = addr[31:16];
                4: v = cnt[15:0];
                default: v = cnt[31:16];
            endcase
            add_exp(1, BASE + 32'(ofs[k] * w), 32'(v));
            if (pair) add_exp(1, BASE + 32'(ofs[k] * w + 2), (k == 1) ? 32'(data[31:16]) : 32'(v));
        end
        if (code == 16'h00E9 || code == 16'h00EA) begin
            add_exp(2, BASE + 32'(8 * w), ptr);
            for (int i = 0; i < int'(cnt); i++) add_exp(1, BASE + ptr + 32'(i), 32'h0000_A000 + 32'(i));
        end
        add_exp(1, BASE + 32'('h60 * w), 32'h1);
        if (pair) add_exp(1, BASE + 32'('h60 * w + 2), 32'h1);
        for (int p = 1; p <= npoll; p++) begin
            add_exp(2, BASE + 32'('h66 * w), 32'(stat_half(p, rl)));
            if (pair) add_exp(2, BASE + 32'('h66 * w + 2), 32'(stat_half(p, rh)));
        end
        add_exp(0, 0, cfg);
        add_exp(0, 1, 32'h2);

        ok  = (log_n == exp_n);
        bad = -1;
        if (ok) begin
            for (int i = 0; i < exp_n; i++) begin
                if (bad < 0 && (log_k[i] != exp_k[i] || log_a[i] != exp_a[i] || log_d[i] != exp_d[i]))
                    bad = i;
            end
        end
        check(ok, "R1/R2/R3/R4/R5/R6/R8", {tag, " trace length"}, 32'(log_n), 32'(exp_n));
        if (ok)
            check(bad < 0, "R1/R2/R3/R4/R5/R6/R8/R10", {tag, " trace entry addr"},
                  (bad < 0) ? 32'h0 : log_a[bad], (bad < 0) ? 32'h0 : exp_a[bad]);
        if (ok && bad >= 0)
            $display("FAIL R10 %s entry %0d data: actual %h expected %h", tag, bad, log_d[bad], exp_d[bad]);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] codes [3] = '{16'h0041, 16'h00E9, 16'h00EA};
        int          cnts  [3] = '{0, 1, 4};
        rst_n = 1'b0; start = 1'b0; pair_mode = 1'b0; cmd_code = '0; cmd_data = '0;
        cmd_addr = '0; cmd_count = '0; poll_limit = '0; pay_valid = 1'b1; pay_data = '0;
        bus_ack = 1'b0; bus_rdata = '0; mr_ack = 1'b0;
        repeat (4) @(negedge clk);
        check({busy, done, error, bus_req, mr_req, pay_ready} == 6'b0, "R9", "reset outputs idle",
              {26'd0, busy, done, error, bus_req, mr_req, pay_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && bus_req == 1'b0, "R9", "idle after reset", {30'd0, busy, bus_req}, 0);

        for (int pr = 0; pr < 2; pr++)
            for (int ci = 0; ci < 3; ci++)
                for (int ni = 0; ni < 3; ni++)
                    run(pr[0], codes[ci], 32'h1234_5678 ^ 32'(ci * 16 + ni), 32'hCAFE_0000 + 32'(ni << 4),
                        32'(cnts[ni]), 8'd8, 1 + ci, 1 + ni, (pr + ci + ni) % 3, ci == 2,
                        $sformatf("sweep p%0d c%0d n%0d", pr, ci, ni));

        run(1'b0, 16'h0020, 32'h0, 32'h0002_0000, 32'h0, 8'd3, 1000, 1000, 0, 0, "R7 single never ready");
        run(1'b1, 16'h0061, 32'h0, 32'h0004_0000, 32'h0, 8'd0, 1000, 1, 1, 0, "R7 pair limit zero");
        run(1'b1, 16'h0062, 32'h0, 32'h0006_0000, 32'h0, 8'd8, 1, 3, 0, 0, "R6 upper half late");
        run(1'b0, 16'h0042, 32'hBEEF, 32'h10, 32'h0, 8'd4, 4, 1, 0, 0, "R7 ready on last poll");
        run(1'b0, 16'h0042, 32'hBEEF, 32'h10, 32'h0, 8'd4, 5, 1, 0, 0, "R7 ready one too late");
        run(1'b1, 16'h00EA, 32'hA5A5_5A5A, 32'hFFFF_0001, 32'd3, 8'd2, 1, 1, 2, 1, "R4 pair buffered slow");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule